// File: doc/BRIEF.md
# Calendar Date Display Decoder

This block turns a running day count into calendar display data. A binary day-of-year value from 1 to 99 and a leap-year control bit enter the block. It works out the calendar month (January to April) and the day within that month. It then sends out the month and date as BCD digits with blanking flags, and as patterns for four seven-segment digits: month tens, month, date tens and date ones.

All outputs are registered, so they follow the inputs by one clock. The day-within-month value goes to its two display digits through a fixed lookup table. No general binary-to-BCD converter is used. The month tens digit is always dark. The date tens digit is dark for dates 1 to 9. A day count outside 1 to 99 darkens every digit.

Top module: `dcal_date_disp`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: `month_bcd`, `date_tens_bcd` and `date_ones_bcd` at 0, both blank flags at 1, `out_valid` at 0, and every segment output at 0.
- R2: Each output reflects the inputs sampled at the previous rising edge: exactly one register stage, no combinational path from input to output.
- R3: Day counts 1 to 31 give month 1, and the date equals the day count.
- R4: February covers days 32 to 59 when `leap_en` is 0 and days 32 to 60 when it is 1. The date is the day count minus 31, so leap day 60 is month 2, date 29.
- R5: March covers days 60 to 90 when not leap and days 61 to 91 when leap. Days 76 and 90 (not leap) give 3/17 and 3/31.
- R6: April covers the remaining days up to 99. Non-leap day 91 and leap day 92 are April 1, and non-leap day 99 is April 9.
- R7: `date_tens_bcd` and `date_ones_bcd` hold the tens and ones decimal digits of the date. Each is in the range 0 to 9, and `month_bcd` holds the month as 1 to 4.
- R8: `date_tens_blank` is 1 exactly when the date is 1 to 9 or the input is invalid. In those cases `seg_date_tens` is all zeros.
- R9: `month_tens_blank` is always 1 and `seg_month_tens` is always all zeros.
- R10: A day count of 0 or above 99 gives `out_valid` 0. All BCD outputs are 0, both blank flags are 1 and every segment output is 0.
- R11: Segment outputs are active high with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 encode as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| doy_bin | input | 7 | Day of year, binary |
| leap_en | input | 1 | 1 = February has 29 days |
| month_bcd | output | 4 | Month digit, BCD |
| date_tens_bcd | output | 4 | Date tens digit, BCD |
| date_ones_bcd | output | 4 | Date ones digit, BCD |
| month_tens_blank | output | 1 | Month tens display dark |
| date_tens_blank | output | 1 | Date tens display dark |
| out_valid | output | 1 | Day count was in range |
| seg_month_tens | output | 7 | Segments, month tens digit |
| seg_month | output | 7 | Segments, month digit |
| seg_date_tens | output | 7 | Segments, date tens digit |
| seg_date_ones | output | 7 | Segments, date ones digit |

## Verification
The bench sweeps every 7-bit day count in both leap settings and compares each output on every clock against a day-by-day model. This targets the month edges that move with `leap_en`. An off-by-one boundary would show 2/29 in a normal year, or push March 31 into April. The 9/10 and 19/20 date edges expose a wrong table row or a tens flag that stays dark at 10. Day counts 0 and 100 to 127 catch a decoder that wraps or shows garbage instead of going dark. A reset applied mid-sweep catches outputs that keep stale digits.

// File: rtl/dcal_pkg.sv
package dcal_pkg;

    localparam int DOY_W    = 7;
    localparam int BCD_W    = 4;
    localparam int SEG_W    = 7;
    localparam int DOM_W    = 5;
    localparam int MON_W    = 3;
    localparam int N_DIGITS = 4;

    typedef struct packed {
        logic             valid;
        logic [MON_W-1:0] month;
        logic [DOM_W-1:0] dom;
    } cal_date_t;

    typedef struct packed {
        logic [BCD_W-1:0] tens;
        logic [BCD_W-1:0] ones;
        logic             tens_blank;
    } dom_digits_t;

    // active-high segments, bit0 = a ... bit6 = g
    function automatic logic [SEG_W-1:0] seg_of(input logic [BCD_W-1:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dcal_month_map.sv
module dcal_month_map
    import dcal_pkg::*;
#(
    parameter int JAN_DAYS = 31,
    parameter int FEB_DAYS = 28,
    parameter int MAR_DAYS = 31,
    parameter int MAX_DOY  = 99
) (
    input  logic [DOY_W-1:0] doy,
    input  logic             leap,
    output cal_date_t        date
);
    localparam logic [DOY_W-1:0] JAN_END  = DOY_W'(JAN_DAYS);
    localparam logic [DOY_W-1:0] FEB_BASE = DOY_W'(JAN_DAYS + FEB_DAYS);
    localparam logic [DOY_W-1:0] MAR_LEN  = DOY_W'(MAR_DAYS);
    localparam logic [DOY_W-1:0] LAST_DOY = DOY_W'(MAX_DOY);

    logic [DOY_W-1:0] feb_end;
    logic [DOY_W-1:0] mar_end;
    logic [DOY_W-1:0] base;

    always_comb begin
        feb_end = FEB_BASE + {{(DOY_W-1){1'b0}}, leap};
        mar_end = feb_end + MAR_LEN;
        date    = '0;
        base    = '0;
        if (doy != '0 && doy <= LAST_DOY) begin
            date.valid = 1'b1;
            if (doy <= JAN_END) begin
                date.month = 3'd1;
                base       = '0;
            end else if (doy <= feb_end) begin
                date.month = 3'd2;
                base       = JAN_END;
            end else if (doy <= mar_end) begin
                date.month = 3'd3;
                base       = feb_end;
            end else begin
                date.month = 3'd4;
                base       = mar_end;
            end
            date.dom = DOM_W'(doy - base);
        end
    end

endmodule

// File: rtl/dcal_dom_split.sv
module dcal_dom_split
    import dcal_pkg::*;
(
    input  logic [DOM_W-1:0] dom,
    output dom_digits_t      dig
);
    logic [2*BCD_W-1:0] pair;

    always_comb begin
        case (dom)
            5'd1:    pair = 8'h01;
            5'd2:    pair = 8'h02;
            5'd3:    pair = 8'h03;
            5'd4:    pair = 8'h04;
            5'd5:    pair = 8'h05;
            5'd6:    pair = 8'h06;
            5'd7:    pair = 8'h07;
            5'd8:    pair = 8'h08;
            5'd9:    pair = 8'h09;
            5'd10:   pair = 8'h10;
            5'd11:   pair = 8'h11;
            5'd12:   pair = 8'h12;
            5'd13:   pair = 8'h13;
            5'd14:   pair = 8'h14;
            5'd15:   pair = 8'h15;
            5'd16:   pair = 8'h16;
            5'd17:   pair = 8'h17;
            5'd18:   pair = 8'h18;
            5'd19:   pair = 8'h19;
            5'd20:   pair = 8'h20;
            5'd21:   pair = 8'h21;
            5'd22:   pair = 8'h22;
            5'd23:   pair = 8'h23;
            5'd24:   pair = 8'h24;
            5'd25:   pair = 8'h25;
            5'd26:   pair = 8'h26;
            5'd27:   pair = 8'h27;
            5'd28:   pair = 8'h28;
            5'd29:   pair = 8'h29;
            5'd30:   pair = 8'h30;
            5'd31:   pair = 8'h31;
            default: pair = 8'h00;
        endcase
        dig.tens       = pair[2*BCD_W-1:BCD_W];
        dig.ones       = pair[BCD_W-1:0];
        dig.tens_blank = (pair[2*BCD_W-1:BCD_W] == '0);
    end

endmodule

// File: rtl/dcal_seg_bank.sv
module dcal_seg_bank
    import dcal_pkg::*;
#(
    parameter int N = N_DIGITS
) (
    input  logic [N-1:0][BCD_W-1:0] digits,
    input  logic [N-1:0]            blank,
    output logic [N-1:0][SEG_W-1:0] segs
);
    for (genvar i = 0; i < N; i++) begin : g_digit
        assign segs[i] = blank[i] ? '0 : seg_of(digits[i]);
    end

endmodule

// File: rtl/dcal_date_disp.sv
module dcal_date_disp
    import dcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DOY_W-1:0] doy_bin,
    input  logic             leap_en,
    output logic [BCD_W-1:0] month_bcd,
    output logic [BCD_W-1:0] date_tens_bcd,
    output logic [BCD_W-1:0] date_ones_bcd,
    output logic             month_tens_blank,
    output logic             date_tens_blank,
    output logic             out_valid,
    output logic [SEG_W-1:0] seg_month_tens,
    output logic [SEG_W-1:0] seg_month,
    output logic [SEG_W-1:0] seg_date_tens,
    output logic [SEG_W-1:0] seg_date_ones
);
    localparam int D_ONES = 0;
    localparam int D_TENS = 1;
    localparam int D_MON  = 2;
    localparam int D_MTEN = 3;

    cal_date_t                     cal;
    dom_digits_t                   dd;
    logic [N_DIGITS-1:0][BCD_W-1:0] dig_vec;
    logic [N_DIGITS-1:0]            blank_vec;
    logic [N_DIGITS-1:0][SEG_W-1:0] seg_vec;

    dcal_month_map u_map (
        .doy  (doy_bin),
        .leap (leap_en),
        .date (cal)
    );

    dcal_dom_split u_split (
        .dom (cal.dom),
        .dig (dd)
    );

    always_comb begin
        dig_vec            = '0;
        blank_vec          = '1;
        if (cal.valid) begin
            dig_vec[D_ONES]   = dd.ones;
            dig_vec[D_TENS]   = dd.tens;
            dig_vec[D_MON]    = {1'b0, cal.month};
            blank_vec[D_ONES] = 1'b0;
            blank_vec[D_TENS] = dd.tens_blank;
            blank_vec[D_MON]  = 1'b0;
        end
    end

    dcal_seg_bank #(.N(N_DIGITS)) u_seg (
        .digits (dig_vec),
        .blank  (blank_vec),
        .segs   (seg_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            month_bcd        <= '0;
            date_tens_bcd    <= '0;
            date_ones_bcd    <= '0;
            month_tens_blank <= 1'b1;
            date_tens_blank  <= 1'b1;
            out_valid        <= 1'b0;
            seg_month_tens   <= '0;
            seg_month        <= '0;
            seg_date_tens    <= '0;
            seg_date_ones    <= '0;
        end else begin
            month_bcd        <= dig_vec[D_MON];
            date_tens_bcd    <= dig_vec[D_TENS];
            date_ones_bcd    <= dig_vec[D_ONES];
            month_tens_blank <= blank_vec[D_MTEN];
            date_tens_blank  <= blank_vec[D_TENS];
            out_valid        <= cal.valid;
            seg_month_tens   <= seg_vec[D_MTEN];
            seg_month        <= seg_vec[D_MON];
            seg_date_tens    <= seg_vec[D_TENS];
            seg_date_ones    <= seg_vec[D_ONES];
        end
    end

endmodule

// File: rtl/dcal_date_disp_chk.sv
module dcal_date_disp_chk
    import dcal_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [DOY_W-1:0] doy_bin,
    input logic             leap_en,
    input logic [BCD_W-1:0] month_bcd,
    input logic [BCD_W-1:0] date_tens_bcd,
    input logic [BCD_W-1:0] date_ones_bcd,
    input logic             month_tens_blank,
    input logic             date_tens_blank,
    input logic             out_valid,
    input logic [SEG_W-1:0] seg_month_tens,
    input logic [SEG_W-1:0] seg_month,
    input logic [SEG_W-1:0] seg_date_tens,
    input logic [SEG_W-1:0] seg_date_ones
);
    // R2
    in_range_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (doy_bin != 0 && doy_bin <= 7'd99) |=> out_valid);

    // R10
    out_range_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (seg_month == 0 && seg_date_tens == 0 && seg_date_ones == 0
                        && month_bcd == 0 && date_tens_blank));

    // R8
    tens_blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        date_tens_blank |-> (seg_date_tens == 0 && date_tens_bcd == 0));

    // R7
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (date_ones_bcd <= 4'd9 && date_tens_bcd <= 4'd3
                       && month_bcd >= 4'd1 && month_bcd <= 4'd4));

    // R6
    april_short_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && month_bcd == 4'd4) |-> (date_tens_bcd == 0 && date_tens_blank));

    // R11
    lit_digit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seg_month != 0 && seg_date_ones != 0));

endmodule

bind dcal_date_disp dcal_date_disp_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .doy_bin          (doy_bin),
    .leap_en          (leap_en),
    .month_bcd        (month_bcd),
    .date_tens_bcd    (date_tens_bcd),
    .date_ones_bcd    (date_ones_bcd),
    .month_tens_blank (month_tens_blank),
    .date_tens_blank  (date_tens_blank),
    .out_valid        (out_valid),
    .seg_month_tens   (seg_month_tens),
    .seg_month        (seg_month),
    .seg_date_tens    (seg_date_tens),
    .seg_date_ones    (seg_date_ones)
);

// File: tb/sim_dcal_date_disp.sv
module sim_dcal_date_disp;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] doy_bin = '0;
    logic       leap_en = 1'b0;
    logic [3:0] month_bcd, date_tens_bcd, date_ones_bcd;
    logic       month_tens_blank, date_tens_blank, out_valid;
    logic [6:0] seg_month_tens, seg_month, seg_date_tens, seg_date_ones;

    int checks = 0;
    int fails  = 0;

    // model state: inputs applied at the previous falling edge
    logic       started = 1'b0;
    logic       m_rst = 1'b1;
    int         m_doy = 0;
    int         m_leap = 0;

    always #4 clk = ~clk;

    dcal_date_disp u0 (
        .clk (clk), .rst (rst), .doy_bin (doy_bin), .leap_en (leap_en),
        .month_bcd (month_bcd), .date_tens_bcd (date_tens_bcd),
        .date_ones_bcd (date_ones_bcd), .month_tens_blank (month_tens_blank),
        .date_tens_blank (date_tens_blank), .out_valid (out_valid),
        .seg_month_tens (seg_month_tens), .seg_month (seg_month),
        .seg_date_tens (seg_date_tens), .seg_date_ones (seg_date_ones)
    );

    function automatic int seg_ref(input int d);
        case (d)
            0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F;
            4: return 'h66; 5: return 'h6D; 6: return 'h7D; 7: return 'h07;
            8: return 'h7F; 9: return 'h6F;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s (day %0d leap %0d): actual %0d expected %0d",
                     tag, what, m_doy, m_leap, act, exp);
        end
    endtask

    task automatic compare();
        int mon, dom, left, tens, ones, valid;
        int mlen [4];
        string mtag;
        if (m_rst) begin
            chk("R1", "month",      month_bcd, 0);
            chk("R1", "tens",       date_tens_bcd, 0);
            chk("R1", "ones",       date_ones_bcd, 0);
            chk("R1", "mtblank",    month_tens_blank, 1);
            chk("R1", "dtblank",    date_tens_blank, 1);
            chk("R1", "valid",      out_valid, 0);
            chk("R1", "segs",       {seg_month_tens, seg_month, seg_date_tens, seg_date_ones}, 0);
            return;
        end
        mlen[0] = 31; mlen[1] = 28 + m_leap; mlen[2] = 31; mlen[3] = 30;
        valid = (m_doy >= 1 && m_doy <= 99);
        mon = 0; dom = 0;
        if (valid) begin
            left = m_doy;
            mon  = 1;
            while (left > mlen[mon-1]) begin
                left -= mlen[mon-1];
                mon++;
            end
            dom = left;
        end
        tens = dom / 10;
        ones = dom % 10;
        case (mon)
            1: mtag = "R3";
            2: mtag = "R4";
            3: mtag = "R5";
            4: mtag = "R6";
            default: mtag = "R10";
        endcase
        chk(valid ? "R2" : "R10", "valid", out_valid, valid);
        chk(mtag, "month", month_bcd, mon);
        chk(valid ? "R7" : "R10", "tens", date_tens_bcd, tens);
        chk(valid ? "R7" : "R10", "ones", date_ones_bcd, ones);
        chk("R8", "dtblank", date_tens_blank, (!valid || dom < 10) ? 1 : 0);
        chk("R9", "mtblank", month_tens_blank, 1);
        chk("R9", "seg_mtens", seg_month_tens, 0);
        chk(valid ? "R11" : "R10", "seg_month", seg_month, valid ? seg_ref(mon) : 0);
        chk("R8", "seg_dtens", seg_date_tens, (valid && dom >= 10) ? seg_ref(tens) : 0);
        chk(valid ? "R11" : "R10", "seg_dones", seg_date_ones, valid ? seg_ref(ones) : 0);
    endtask

    task automatic step(input logic r, input int d, input int lp);
        @(negedge clk);
        if (started) compare();
        rst     = r;
        doy_bin = 7'(d);
        leap_en = lp[0];
        m_rst   = r;
        m_doy   = d;
        m_leap  = lp;
        started = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset with a live day value on the input
        step(1'b1, 45, 0);
        step(1'b1, 45, 0);
        // full sweep both settings: R3..R6, R10
        for (int lp = 0; lp < 2; lp++)
            for (int d = 0; d < 128; d++)
                step(1'b0, d, lp);
        // named corners
        step(1'b0, 15, 0);
        step(1'b0, 90, 0);
        step(1'b0, 76, 0);
        step(1'b0, 60, 1);
        step(1'b0, 60, 0);
        step(1'b0, 91, 1);
        step(1'b0, 92, 1);
        step(1'b0, 99, 0);
        step(1'b0, 100, 1);
        // reset mid-run clears stale digits
        step(1'b1, 88, 0);
        step(1'b0, 31, 0);
        step(1'b0, 32, 1);
        // scattered values, leap flipping each cycle
        for (int k = 0; k < 60; k++)
            step(1'b0, int'($urandom_range(0, 127)), k % 2);
        step(1'b0, 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule